// File: doc/BRIEF.md
# Eight-bit multi-mode timer with compare output

An 8-bit counter advances on each cycle in which an external prescaler raises its tick input. One compare register drives a single waveform output. A mode field selects how the counter runs: free-running, restart on compare, single-slope (fast) PWM or dual-slope (phase-correct) PWM. A 2-bit action code sets what the waveform output does on compare and period events.

Two status flags record events: overflow and compare. Each flag is cleared by pulsing a 1 on its own clear bit. Each flag has an enable bit, and the flag ANDed with its enable gives an interrupt request.

A simple write port loads the count, the compare value or the control byte. In the two PWM modes the compare value is double-buffered, so a duty-cycle change starts cleanly at the next period.

Top module: `cmp_timer8`

## Requirements
- R1: In free-running mode (mode 0) each tick increments the count, wrapping 0xFF to 0x00. A tick taken while the count is 0xFF raises the overflow flag.
- R2: While tick is low and the count is not written, the count, the output and the flags hold.
- R3: In restart mode (mode 1), a tick taken while the count equals the active compare value loads 0x00 instead of incrementing. The same tick raises the compare flag and applies the action code to the output.
- R4: In modes 0 and 1 the action code on a match is: 0 = no change, 1 = toggle, 2 = drive low, 3 = drive high. A match also raises the compare flag in mode 0.
- R5: In fast PWM mode (mode 2), a match does not restart the counter and never raises the compare flag. With code 2 a match drives the output low; with code 3 it drives it high. A tick taken at 0xFF drives the opposite level (this wins on a tie), wraps the count to 0x00 and raises the overflow flag.
- R6: In dual-slope mode (mode 3), the counter climbs 0x00 to 0xFF and then descends. The tick at 0xFF gives 0xFE, and the tick at 0x00 while descending gives 0x01 and raises the overflow flag.
- R7: In mode 3, with code 2, a match while climbing drives the output low and a match while descending drives it high. Code 3 swaps these levels. A match raises the compare flag, and the turn at 0xFF alone never changes the output.
- R8: In modes 0 and 1 a compare write takes effect at once. In modes 2 and 3 it goes to a buffer, which becomes active only on the tick at 0xFF (while climbing in mode 3).
- R9: Pulsing clr_flags bit 0 clears the overflow flag and bit 1 clears the compare flag. A 0 bit leaves its flag unchanged.
- R10: ovf_irq equals the overflow flag AND control bit 4; cmp_irq equals the compare flag AND control bit 5.
- R11: A count write wins over a tick in the same cycle: the count takes the written value and no match or flag event occurs in that cycle.
- R12: Write select 0 loads the count, 1 the compare value and 2 the control byte. The control byte holds the mode in bits [1:0], the action code in [3:2], the overflow enable in bit 4 and the compare enable in bit 5. A control write sets the dual-slope direction to climbing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable from the prescaler |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Write target: 0 count, 1 compare, 2 control |
| wr_data | input | 8 | Write data |
| clr_flags | input | 2 | Write-1-to-clear: bit 0 overflow, bit 1 compare |
| count | output | 8 | Current count |
| wave | output | 1 | Waveform output |
| ovf_flag | output | 1 | Overflow flag |
| cmp_flag | output | 1 | Compare flag |
| ovf_irq | output | 1 | Overflow interrupt request |
| cmp_irq | output | 1 | Compare interrupt request |

## Verification
Each mode is run from counts placed next to its events: the wrap at 0xFF, a compare match, the top of the period and the descending bottom. Flags and output levels are sampled one tick before and one tick after each event, which shows on exactly which tick each event fires.

In fast PWM, a compare value is written mid-period while an older value stays active. The output then switches at the old value in the current period and at the new value after the top, which separates buffered from direct loading.

A dual-slope run descends through the match and then climbs back through it. This shows the two direction-dependent levels, and shows that the overflow flag is raised at the bottom rather than at the top.

// File: rtl/cmp_timer8.sv
module cmp_timer8 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic [1:0]   clr_flags,
  output logic [W-1:0] count,
  output logic         wave,
  output logic         ovf_flag,
  output logic         cmp_flag,
  output logic         ovf_irq,
  output logic         cmp_irq
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  localparam logic [W-1:0] BOT = '0;
  localparam logic [1:0] M_FREE = 2'd0, M_CTC = 2'd1, M_FAST = 2'd2, M_DUAL = 2'd3;

  logic [W-1:0] cnt, ocr, ocr_buf;
  logic [5:0]   ctl;
  logic         down;

  wire [1:0] mode   = ctl[1:0];
  wire [1:0] act    = ctl[3:2];
  wire       cnt_wr = wr_en && wr_sel == 2'd0;
  wire       ocr_wr = wr_en && wr_sel == 2'd1;
  wire       ctl_wr = wr_en && wr_sel == 2'd2;
  wire       step   = tick && !cnt_wr;
  wire       at_top = cnt == TOP;
  wire       at_bot = cnt == BOT;
  wire       match  = cnt == ocr;
  wire       pwm    = mode[1];

  logic [W-1:0] cnt_nx;
  logic         ovf_ev, cmp_ev, load_ev, wave_nx;

  always_comb begin
    cnt_nx  = cnt + 1'b1;
    ovf_ev  = 1'b0;
    load_ev = 1'b0;
    wave_nx = wave;
    cmp_ev  = step && match && mode != M_FAST;
    case (mode)
      M_FREE, M_CTC: begin
        if (mode == M_CTC && match) cnt_nx = BOT;
        ovf_ev = step && at_top && !(mode == M_CTC && match);
        if (match)
          case (act)
            2'd1:    wave_nx = ~wave;
            2'd2:    wave_nx = 1'b0;
            2'd3:    wave_nx = 1'b1;
            default: wave_nx = wave;
          endcase
      end
      M_FAST: begin
        ovf_ev  = step && at_top;
        load_ev = step && at_top;
        if (act[1] && match)  wave_nx = act[0];
        if (act[1] && at_top) wave_nx = ~act[0];
      end
      default: begin
        if (down) cnt_nx = at_bot ? BOT + 1'b1 : cnt - 1'b1;
        else      cnt_nx = at_top ? TOP - 1'b1 : cnt + 1'b1;
        ovf_ev  = step && down && at_bot;
        load_ev = step && !down && at_top;
        if (act[1] && match) wave_nx = down ? ~act[0] : act[0];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0; ocr <= '0; ocr_buf <= '0; ctl <= '0; down <= 1'b0;
      wave <= 1'b0; ovf_flag <= 1'b0; cmp_flag <= 1'b0;
    end else begin
      if (cnt_wr)    cnt <= wr_data;
      else if (tick) cnt <= cnt_nx;
      if (ctl_wr) begin
        ctl  <= wr_data[5:0];
        down <= 1'b0;
      end else if (step && mode == M_DUAL) begin
        down <= down ? !at_bot : at_top;
      end
      if (ocr_wr) ocr_buf <= wr_data;
      if (ocr_wr && !pwm) ocr <= wr_data;
      else if (load_ev)   ocr <= ocr_buf;
      if (step) wave <= wave_nx;
      ovf_flag <= (ovf_flag && !clr_flags[0]) || ovf_ev;
      cmp_flag <= (cmp_flag && !clr_flags[1]) || cmp_ev;
    end

  assign count   = cnt;
  assign ovf_irq = ovf_flag && ctl[4];
  assign cmp_irq = cmp_flag && ctl[5];

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick && !cnt_wr |=> $stable(count) && $stable(wave));

  // R11
  cnt_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> count == $past(wr_data) && !$rose(cmp_flag));

  // R5
  fast_nocmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_FAST && !ctl_wr |=> !$rose(cmp_flag));

  // R9
  ovf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_flags[0] && !tick |=> !ovf_flag);

  // R3
  ctc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_CTC && step && match |=> count == BOT && cmp_flag);

  // R6
  dual_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode == M_DUAL && step && !ctl_wr && !down && at_top |=> count == TOP - 1'b1);
endmodule

// File: tb/cmp_timer8_tb.sv
module cmp_timer8_tb;
  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_sel = '0, clr_flags = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] count;
  logic       wave, ovf_flag, cmp_flag, ovf_irq, cmp_irq;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  cmp_timer8 u_dut (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .clr_flags(clr_flags), .count(count), .wave(wave),
    .ovf_flag(ovf_flag), .cmp_flag(cmp_flag), .ovf_irq(ovf_irq), .cmp_irq(cmp_irq));

  always #10 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ticks(int n);
    @(negedge clk) tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] d);
    @(negedge clk) begin wr_en = 1'b1; wr_sel = sel; wr_data = d; end
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic clr(logic [1:0] b);
    @(negedge clk) clr_flags = b;
    @(negedge clk) clr_flags = 2'b00;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R12 reset count", count, 0);
    chk("R12 reset wave", wave, 0);
    chk("R9 reset flags", {ovf_flag, cmp_flag, ovf_irq, cmp_irq}, 0);
  endtask

  task automatic t_free;
    wr(2, 8'h1C);
    wr(1, 8'hFF);
    wr(0, 8'hFE);
    ticks(1);
    chk("R1 count FF", count, 8'hFF);
    chk("R1 no ovf yet", ovf_flag, 0);
    ticks(1);
    chk("R1 wrap", count, 0);
    chk("R1 ovf at FF", ovf_flag, 1);
    chk("R4 code3 drives high", wave, 1);
    chk("R4 cmp flag in mode 0", cmp_flag, 1);
    chk("R10 ovf_irq", ovf_irq, 1);
    chk("R10 cmp_irq disabled", cmp_irq, 0);
    repeat (4) @(negedge clk);
    chk("R2 count holds", count, 0);
    chk("R2 wave holds", wave, 1);
  endtask

  task automatic t_w1c;
    clr(2'b10);
    chk("R9 cmp cleared", cmp_flag, 0);
    chk("R9 ovf kept", ovf_flag, 1);
    clr(2'b01);
    chk("R9 ovf cleared", ovf_flag, 0);
    chk("R10 ovf_irq low", ovf_irq, 0);
  endtask

  task automatic t_ctc;
    wr(2, 8'h05);
    wr(1, 8'h05);
    wr(0, 8'h00);
    ticks(5);
    chk("R3 count at match", count, 5);
    chk("R3 wave before match", wave, 1);
    ticks(1);
    chk("R3 restart", count, 0);
    chk("R4 toggle", wave, 0);
    chk("R3 cmp flag", cmp_flag, 1);
    ticks(6);
    chk("R4 toggle again", wave, 1);
    clr(2'b11);
  endtask

  task automatic t_prio;
    @(negedge clk) begin wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h05; tick = 1'b1; end
    @(negedge clk) begin wr_en = 1'b0; tick = 1'b0; end
    chk("R11 write wins", count, 5);
    chk("R11 no cmp event", cmp_flag, 0);
    chk("R11 wave unchanged", wave, 1);
    ticks(1);
    chk("R11 match next tick", count, 0);
    chk("R11 wave toggled next tick", wave, 0);
    clr(2'b11);
  endtask

  task automatic t_fast;
    wr(2, 8'h0E);
    wr(1, 8'h20);
    wr(0, 8'h00);
    ticks(6);
    chk("R8 old compare still active", wave, 1);
    chk("R5 no cmp flag", cmp_flag, 0);
    chk("R5 no restart", count, 6);
    wr(0, 8'hFE);
    ticks(1);
    chk("R5 no ovf before FF tick", ovf_flag, 0);
    ticks(1);
    chk("R5 top opposite level", wave, 0);
    chk("R5 ovf at FF", ovf_flag, 1);
    chk("R5 wrap", count, 0);
    ticks(32);
    chk("R8 count at new compare", count, 8'h20);
    chk("R8 wave before new match", wave, 0);
    ticks(1);
    chk("R8 new compare active", wave, 1);
    chk("R5 still no cmp flag", cmp_flag, 0);
    clr(2'b11);
  endtask

  task automatic t_dual;
    wr(2, 8'h2F);
    wr(1, 8'h30);
    wr(0, 8'hFD);
    ticks(3);
    chk("R6 turn at FF", count, 8'hFE);
    chk("R7 top leaves wave", wave, 1);
    chk("R6 no ovf at top", ovf_flag, 0);
    ticks(8'hCE);
    chk("R6 descending", count, 8'h30);
    ticks(1);
    chk("R7 down match code3 low", wave, 0);
    chk("R7 cmp flag", cmp_flag, 1);
    chk("R10 cmp_irq", cmp_irq, 1);
    ticks(8'h2F);
    chk("R6 bottom", count, 0);
    chk("R6 no ovf before bottom tick", ovf_flag, 0);
    ticks(1);
    chk("R6 turn at bottom", count, 1);
    chk("R6 ovf at bottom", ovf_flag, 1);
    ticks(8'h2F);
    chk("R7 wave before up match", wave, 0);
    ticks(1);
    chk("R7 up match code3 high", wave, 1);
    chk("R6 climbing", count, 8'h31);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_free;
    t_w1c;
    t_ctc;
    t_prio;
    t_fast;
    t_dual;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
    $finish;
  end
endmodule